// File: doc/BRIEF.md
# Burst-of-Four Separate-I/O SRAM Pipeline

This block is a synthesizable behavioural model of a synchronous SRAM that has a separate read port and write port behind one shared address bus. Each port moves four beats per command. Every rising clock edge samples an active-low read request and an active-low write request. An accepted write takes its four beats over the next two cycles. An accepted read returns its four beats over two cycles, starting three cycles after the command.

Double-data-rate transfer is modelled as two half-words per clock, one for the rising half and one for the falling half. Each half-word has its own output-enable. When no read data is due, an idle policy input chooses what the output does in that cycle. It either drives zero with the enable high (termination on), or it releases the bus with the enable low.

The array stores whole four-beat words. The address picks one burst-aligned word. A write commits its word only after the last beat has been captured.

Top module: `burst_sram`

## Requirements
- R1: While `rstN` is low, `qOeRise` and `qOeFall` are 0 and `qRise` and `qFall` are 0.
- R2: After a write accepted at edge n, the edge n+1 captures `wdRise` as beat 0 and `wdFall` as beat 1. The edge n+2 captures `wdRise` as beat 2 and `wdFall` as beat 3. Beat k occupies bits [k*DW +: DW] of the stored word.
- R3: After a read accepted at edge n, the values following edge n+3 are `qRise`=beat 0 and `qFall`=beat 1. The values following edge n+4 are beat 2 and beat 3. Both enables are 1 in both cycles.
- R4: A write request at the edge right after an accepted write is ignored, and the array is not changed. A write request two edges after an accepted write is accepted.
- R5: A read request at the edge right after an accepted read is ignored, and the output shows no new burst. A read request two edges after an accepted read is accepted.
- R6: The two ports work independently. A read and a write are both accepted when issued at the same edge, or at adjacent edges, or when streamed every other cycle.
- R7: A read returns the word as changed by every write accepted at or before the read's own edge, including a write to the same address at the same edge. It does not see a write accepted at a later edge.
- R8: After edge n+3, if no read was accepted at edge n or edge n-1, the cycle is idle. `qRise` and `qFall` are 0, and both enables equal the value of `odtEn` sampled at edge n+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| rdN | input | 1 | Read request, active low |
| wrN | input | 1 | Write request, active low |
| addr | input | AW | Shared word address |
| wdRise | input | DW | Write beat for the rising half |
| wdFall | input | DW | Write beat for the falling half |
| odtEn | input | 1 | Idle policy: 1 drives zero, 0 releases |
| qRise | output | DW | Read beat for the rising half |
| qFall | output | DW | Read beat for the falling half |
| qOeRise | output | 1 | Output-enable, rising half |
| qOeFall | output | 1 | Output-enable, falling half |

## Verification
The bench issues back-to-back requests on one port. A design that accepted the second one would show an extra burst, or would overwrite a word that a later read expects unchanged. The bench also reads an address at the same edge as a write to it, and one edge before such a write. A design that sampled the array at the wrong time would return stale data in the first case or early data in the second. Idle cycles are checked with termination both on and off, including the cycle that follows a burst's second half. A design that dropped the "preceded by a read" exception, or mixed up the beat order, would show the wrong enable or the wrong half-word.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  // fixed protocol latencies, in clock edges
  localparam int RD_LAT = 3;
  localparam int BEATS  = 4;

  typedef struct packed {
    logic capLo;       // capture first two write beats
    logic commit;      // store full word with last two beats
    logic loadFirst;   // present first half of a read burst
    logic sendSecond;  // present second half of a read burst
  } ctrlStrobeT;
endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import burst_sram_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdN,
  input  logic          wrN,
  input  logic [AW-1:0] addr,
  output ctrlStrobeT    stb,
  output logic [AW-1:0] wAddr,
  output logic [AW-1:0] rAddr
);
  logic              wPend1, wPend2;
  logic              rSecond;
  logic [RD_LAT-1:0] rVld;
  logic [AW-1:0]     rAddrP [RD_LAT];
  logic              wrAcc, rdAcc;

  // a port busy with the second cycle of its burst ignores its request
  assign wrAcc = !wrN && !wPend1;
  assign rdAcc = !rdN && !rVld[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wPend1  <= 1'b0;
      wPend2  <= 1'b0;
      rVld    <= '0;
      rSecond <= 1'b0;
    end else begin
      wPend1  <= wrAcc;
      wPend2  <= wPend1;
      rVld    <= {rVld[RD_LAT-2:0], rdAcc};
      rSecond <= rVld[RD_LAT-1];
    end
  end

  always_ff @(posedge clk) begin
    if (wrAcc) wAddr <= addr;
    rAddrP[0] <= addr;
  end

  for (genvar st = 1; st < RD_LAT; st++) begin : gRdAddr
    always_ff @(posedge clk) rAddrP[st] <= rAddrP[st-1];
  end

  assign rAddr          = rAddrP[RD_LAT-1];
  assign stb.capLo      = wPend1;
  assign stb.commit     = wPend2;
  assign stb.loadFirst  = rVld[RD_LAT-1];
  assign stb.sendSecond = rSecond;
endmodule

// File: rtl/bsr_datapath.sv
module bsr_datapath
  import burst_sram_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobeT    stb,
  input  logic [AW-1:0] wAddr,
  input  logic [AW-1:0] rAddr,
  input  logic [DW-1:0] wdRise,
  input  logic [DW-1:0] wdFall,
  input  logic          odtEn,
  output logic [DW-1:0] qRise,
  output logic [DW-1:0] qFall,
  output logic          qOeRise,
  output logic          qOeFall
);
  localparam int DEPTH  = 1 << AW;
  localparam int WORD_W = BEATS * DW;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [2*DW-1:0]   loBeats;
  logic [WORD_W-1:0] rdWord;

  always_ff @(posedge clk) begin
    if (stb.capLo)  loBeats    <= {wdFall, wdRise};
    if (stb.commit) mem[wAddr] <= {wdFall, wdRise, loBeats};
  end

  // array sampled at the edge the first half leaves, so writes committed
  // up to the edge before are visible and later ones are not
  assign rdWord = mem[rAddr];

  // lane 0 = rising half, lane 1 = falling half
  for (genvar ln = 0; ln < 2; ln++) begin : gLane
    logic [DW-1:0] q;
    logic [DW-1:0] hold;
    logic          oe;

    always_ff @(posedge clk) begin
      if (stb.loadFirst) hold <= rdWord[(ln+2)*DW +: DW];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q  <= '0;
        oe <= 1'b0;
      end else if (stb.loadFirst) begin
        q  <= rdWord[ln*DW +: DW];
        oe <= 1'b1;
      end else if (stb.sendSecond) begin
        q  <= hold;
        oe <= 1'b1;
      end else begin
        q  <= '0;
        oe <= odtEn;
      end
    end
  end

  assign qRise   = gLane[0].q;
  assign qFall   = gLane[1].q;
  assign qOeRise = gLane[0].oe;
  assign qOeFall = gLane[1].oe;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdN,
  input  logic          wrN,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdRise,
  input  logic [DW-1:0] wdFall,
  input  logic          odtEn,
  output logic [DW-1:0] qRise,
  output logic [DW-1:0] qFall,
  output logic          qOeRise,
  output logic          qOeFall
);
  ctrlStrobeT    stb;
  logic [AW-1:0] wAddr, rAddr;

  bsr_ctrl #(.AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .rdN(rdN), .wrN(wrN), .addr(addr),
    .stb(stb), .wAddr(wAddr), .rAddr(rAddr)
  );

  bsr_datapath #(.AW(AW), .DW(DW)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wAddr(wAddr), .rAddr(rAddr),
    .wdRise(wdRise), .wdFall(wdFall), .odtEn(odtEn),
    .qRise(qRise), .qFall(qFall), .qOeRise(qOeRise), .qOeFall(qOeFall)
  );
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          rdN,
  input logic          odtEn,
  input logic [DW-1:0] qRise,
  input logic [DW-1:0] qFall,
  input logic          qOeRise,
  input logic          qOeFall
);
  // acc[k]: a read was accepted k edges before the current sample edge
  logic [5:1] acc;
  logic [1:0] settle;
  logic       accNow;

  assign accNow = !rdN && !acc[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      settle <= '0;
    end else begin
      acc    <= {acc[4:1], accNow};
      if (settle != 2'd3) settle <= settle + 2'd1;
    end
  end

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (settle != 0 && (acc[4] || acc[5])) |-> (qOeRise && qOeFall)); // R3

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (settle != 0 && !acc[4] && !acc[5] && $past(odtEn))
      |-> (qOeRise && qOeFall && qRise == '0 && qFall == '0)); // R8

  AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    (settle != 0 && !acc[4] && !acc[5] && !$past(odtEn))
      |-> (!qOeRise && !qOeFall)); // R8

  AST_OE_PAIRED: assert property (@(posedge clk) disable iff (!rstN)
    (settle != 0) |-> (qOeRise == qOeFall)); // R3
endmodule

bind burst_sram bsr_checker #(.DW(DW)) uChk (
  .clk(clk), .rstN(rstN), .rdN(rdN), .odtEn(odtEn),
  .qRise(qRise), .qFall(qFall), .qOeRise(qOeRise), .qOeFall(qOeFall)
);

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int WW = 4 * DW;

  logic          clk = 1'b0;
  logic          rstN, rdN, wrN, odtEn;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdRise, wdFall, qRise, qFall;
  logic          qOeRise, qOeFall;

  always #2 clk = ~clk;   // 250 MHz

  burst_sram #(.AW(AW), .DW(DW)) dut (.*);

  typedef struct {
    logic          oe;
    logic [DW-1:0] r;
    logic [DW-1:0] f;
    string         tag;
  } expT;

  expT expQ[$];
  int  checks = 0;
  int  errors = 0;

  // reference state
  logic [WW-1:0] mMem [1<<AW];
  logic [WW-1:0] mHold;
  bit            wp1 = 0, wp2 = 0;
  logic [AW-1:0] wa1, wa2;
  logic [WW-1:0] wW1, wW2;
  bit            rv [1:4] = '{0, 0, 0, 0};
  logic [AW-1:0] ra [1:4];
  string         rt [1:4];

  task automatic step(input bit rd, input bit wr, input logic [AW-1:0] a,
                      input bit odt, input string tag);
    expT           e;
    logic [WW-1:0] w;
    bit            wacc, racc;
    @(negedge clk);
    rdN = !rd; wrN = !wr; addr = a; odtEn = odt;
    if (wp1) begin
      wdRise = wW1[DW-1:0];      wdFall = wW1[2*DW-1:DW];
    end else if (wp2) begin
      wdRise = wW2[3*DW-1:2*DW]; wdFall = wW2[4*DW-1:3*DW];
    end else begin
      wdRise = DW'($urandom);    wdFall = DW'($urandom);
    end
    // output expected right after this edge
    if (rv[3]) begin
      w = mMem[ra[3]];
      e.oe = 1'b1; e.r = w[DW-1:0]; e.f = w[2*DW-1:DW]; e.tag = rt[3];
      mHold = w;
    end else if (rv[4]) begin
      e.oe = 1'b1; e.r = mHold[3*DW-1:2*DW]; e.f = mHold[4*DW-1:3*DW];
      e.tag = rt[4];
    end else begin
      e.oe = odt; e.r = '0; e.f = '0; e.tag = "R8";
    end
    expQ.push_back(e);
    if (wp2) mMem[wa2] = wW2;
    wacc = wr && !wp1;
    wp2 = wp1; wa2 = wa1; wW2 = wW1;
    wp1 = wacc;
    if (wacc) begin wa1 = a; wW1 = WW'($urandom); end
    racc = rd && !rv[1];
    for (int k = 4; k >= 2; k--) begin
      rv[k] = rv[k-1]; ra[k] = ra[k-1]; rt[k] = rt[k-1];
    end
    rv[1] = racc; ra[1] = a; rt[1] = tag;
  endtask

  // monitor / scoreboard
  initial begin
    expT e;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        checks++;
        if (qOeRise !== e.oe || qOeFall !== e.oe || qRise !== e.r || qFall !== e.f) begin
          errors++;
          $display("FAIL %s: got oe=%b/%b r=%h f=%h, expected oe=%b r=%h f=%h",
                   e.tag, qOeRise, qOeFall, qRise, qFall, e.oe, e.r, e.f);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; rdN = 1'b1; wrN = 1'b1; addr = '0;
    wdRise = '0; wdFall = '0; odtEn = 1'b1;
    repeat (4) @(negedge clk);
    checks++;   // R1 reset state with termination requested
    if (qOeRise !== 1'b0 || qOeFall !== 1'b0 || qRise !== '0 || qFall !== '0) begin
      errors++;
      $display("FAIL R1: got oe=%b/%b r=%h f=%h, expected oe=0 r=00 f=00",
               qOeRise, qOeFall, qRise, qFall);
    end
    rstN = 1'b1;

    // R2: fill every word
    for (int a = 0; a < (1 << AW); a++) begin
      step(0, 1, AW'(a), a[0], "R2");
      step(0, 0, '0, !a[0], "R2");
    end
    // R2 R3: read every word back, bursts streamed
    for (int a = 0; a < (1 << AW); a++) begin
      step(1, 0, AW'(a), a[1], "R2 R3");
      step(0, 0, '0, 1'b1, "R2 R3");
    end
    repeat (3) step(0, 0, '0, 1'b0, "R8");
    repeat (3) step(0, 0, '0, 1'b1, "R8");

    // R5: second read right after is ignored
    step(1, 0, 4'd5, 1'b0, "R5");
    step(1, 0, 4'd6, 1'b0, "R5");
    repeat (4) step(0, 0, '0, 1'b0, "R5");

    // R4: second write right after is ignored; word 8 keeps old value
    step(0, 1, 4'd7, 1'b1, "R4");
    step(0, 1, 4'd8, 1'b1, "R4");
    step(0, 0, '0, 1'b1, "R4");
    step(1, 0, 4'd8, 1'b1, "R4");
    step(0, 0, '0, 1'b1, "R4");
    step(1, 0, 4'd7, 1'b1, "R4");
    step(0, 0, '0, 1'b1, "R4");

    // R6: overlapping ports
    step(0, 1, 4'd9, 1'b0, "R6");
    step(1, 0, 4'd9, 1'b0, "R6");
    step(0, 1, 4'd10, 1'b0, "R6");
    step(1, 0, 4'd10, 1'b0, "R6");
    step(0, 0, '0, 1'b0, "R6");

    // R7: same-edge write is seen, later write is not
    step(1, 1, 4'd11, 1'b1, "R7");
    step(0, 0, '0, 1'b1, "R7");
    step(1, 0, 4'd11, 1'b1, "R7");
    step(0, 1, 4'd11, 1'b1, "R7");
    step(0, 0, '0, 1'b1, "R7");
    step(1, 0, 4'd11, 1'b0, "R7");
    step(0, 0, '0, 1'b0, "R7");

    // R6 R7: both ports streamed every other cycle on the same word
    for (int i = 0; i < 8; i++) begin
      step(1, 1, AW'(i + 2), i[0], "R6 R7");
      step(0, 0, '0, i[1], "R6 R7");
    end

    repeat (6) step(0, 0, '0, 1'b1, "R8");
    repeat (2) step(0, 0, '0, 1'b0, "R8");
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule